// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block puts a two-wire serial bus back into a known idle condition when a slave device may have been interrupted partway through a byte and is still holding the data line low. It owns the clock and data lines only while it runs. It drives each line through an open-drain style enable, where asserting the enable pulls the line low and releasing it lets the pull-up take the line high. It reads the data line back while the clock line is high.

Recovery starts when a request is raised. It also starts on its own when a transfer engine asks for the bus for the first time after reset. The sequencer first pulls the clock line low and then lets go of the data line. It then toggles the clock up to nine times. As soon as the slave lets go of the data line, it pulls data low while the clock is high and then pulls the clock low. When it finishes, it returns both lines and reports the result with a one-cycle completion pulse and a pass/fail bit. The time between line changes is a number of system clocks taken from an input.

Top module: `i2c_unstick`

## Requirements
- R1: During reset and in the first cycle after it, busy_o, done_o, init_o, scl_oe_o and sda_oe_o are all 0. An enable of 1 means the line is pulled low.
- R2: A req_i sampled high while idle starts a run. In the first busy cycle scl_oe_o=1 and sda_oe_o=0, so the clock is pulled low before the data line is left free.
- R3: Every line phase lasts G cycles, where G is gap_i, or 1 when gap_i is 0. A run that succeeds on pulse k is busy for (2k+3)*G cycles. A run that fails is busy for 20*G cycles.
- R4: Data is sampled at the final edge of each clock-high phase. If it reads high, sda_oe_o goes to 1 while scl_oe_o is 0, and scl_oe_o goes to 1 one phase later. The run then ends with pass_o=1, and the last busy cycle has both enables at 1.
- R5: At most 9 clock pulses are made, each one a fall of scl_oe_o. If data reads low on all 9, the run ends with pass_o=0, and the last busy cycle has scl_oe_o=1 and sda_oe_o=0.
- R6: done_o is high for exactly one cycle: the first cycle in which busy_o is low after a run. pass_o is valid in that cycle.
- R7: req_i and xfer_req_i are ignored while busy_o is high. They neither lengthen the run nor start another one.
- R8: xfer_req_i sampled high while idle and init_o=0 starts a run. init_o goes to 1 with the done pulse of any run, pass or fail. Once init_o is 1, xfer_req_i alone starts nothing.
- R9: Whenever busy_o is low, both scl_oe_o and sda_oe_o are 0.
- R10: A req_i that is high in the done_o cycle starts a new run, so busy_o is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gap_i | input | GAP_W | System clocks per line phase (0 treated as 1) |
| req_i | input | 1 | Explicit recovery request |
| xfer_req_i | input | 1 | A transfer wants the bus; starts recovery if the bus is not yet initialised |
| sda_i | input | 1 | Sampled level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of the last run (1 = data line released) |
| init_o | output | 1 | At least one recovery has completed since reset |

## Verification
Two things can happen in the same cycle: a run's completion pulse and the acceptance of a new request. The bench holds req_i high through the done_o cycle. It expects busy_o to return in the very next cycle, and it expects the scoreboard to see two full runs with the right lengths. A second case checks that requests arriving in the middle of a run or during its closing phase are dropped. Here the scoreboard expects the same length as an undisturbed run, and busy_o must stay low after the done pulse.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

    localparam int unsigned RCV_PULSES = 9;
    localparam int unsigned RCV_CW     = $clog2(RCV_PULSES + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULL_SCL,
        ST_FREE_SDA,
        ST_SCL_HI,
        ST_SCL_LO,
        ST_GRAB_SDA,
        ST_GRAB_SCL
    } rcv_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    // Line enables implied by each phase of the sequence.
    function automatic line_drive_t drive_for(rcv_state_e s);
        line_drive_t d;
        d.scl_low = (s == ST_PULL_SCL) || (s == ST_FREE_SDA) ||
                    (s == ST_SCL_LO)   || (s == ST_GRAB_SCL);
        d.sda_low = (s == ST_GRAB_SDA) || (s == ST_GRAB_SCL);
        return d;
    endfunction

    // Phase that follows when the current one's interval expires.
    function automatic rcv_state_e step_after(rcv_state_e s, logic sda_hi, logic last_pulse);
        case (s)
            ST_PULL_SCL: return ST_FREE_SDA;
            ST_FREE_SDA: return ST_SCL_HI;
            ST_SCL_HI:   return sda_hi ? ST_GRAB_SDA : ST_SCL_LO;
            ST_SCL_LO:   return last_pulse ? ST_IDLE : ST_SCL_HI;
            ST_GRAB_SDA: return ST_GRAB_SCL;
            default:     return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/rcv_gap_timer.sv
module rcv_gap_timer #(
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [GAP_W-1:0] gap,
    output logic             expire
);
    logic [GAP_W-1:0] cnt_q;
    logic [GAP_W-1:0] lim;

    assign lim    = (gap == '0) ? '0 : gap - 1'b1;
    assign expire = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || expire) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rcv_pulse_ctr.sv
module rcv_pulse_ctr
    import rcv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    logic [RCV_CW-1:0] cnt_q;

    assign last = (cnt_q == RCV_CW'(RCV_PULSES - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (inc)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rcv_trigger.sv
module rcv_trigger (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic req,
    input  logic xfer_req,
    input  logic finish,
    output logic start,
    output logic init
);
    logic init_q;

    assign start = idle && (req || (xfer_req && !init_q));
    assign init  = init_q;

    always_ff @(posedge clk) begin
        if (rst)         init_q <= 1'b0;
        else if (finish) init_q <= 1'b1;
    end
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
    import rcv_pkg::*;
#(
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             req_i,
    input  logic             xfer_req_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             init_o
);
    rcv_state_e  st_q, st_d;
    line_drive_t drv;
    logic        idle, start, expire, last_pulse, finish;
    logic        done_q, pass_q;

    assign idle = (st_q == ST_IDLE);

    rcv_trigger u_trig (
        .clk      (clk),
        .rst      (rst),
        .idle     (idle),
        .req      (req_i),
        .xfer_req (xfer_req_i),
        .finish   (finish),
        .start    (start),
        .init     (init_o)
    );

    rcv_gap_timer #(.GAP_W(GAP_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (!idle),
        .gap    (gap_i),
        .expire (expire)
    );

    rcv_pulse_ctr u_pulses (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .inc  (expire && (st_q == ST_SCL_LO)),
        .last (last_pulse)
    );

    assign finish = expire && (((st_q == ST_SCL_LO) && last_pulse) || (st_q == ST_GRAB_SCL));

    always_comb begin
        st_d = st_q;
        if (start)       st_d = ST_PULL_SCL;
        else if (expire) st_d = step_after(st_q, sda_i, last_pulse);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= finish;
            if (finish) pass_q <= (st_q == ST_GRAB_SCL);
        end
    end

    assign drv      = drive_for(st_q);
    assign scl_oe_o = drv.scl_low;
    assign sda_oe_o = drv.sda_low;
    assign busy_o   = !idle;
    assign done_o   = done_q;
    assign pass_o   = pass_q;
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk
    import rcv_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic busy_o,
    input logic done_o,
    input logic init_o
);
    logic              scl_prev;
    logic [RCV_CW-1:0] falls;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b0;
            falls    <= '0;
        end else begin
            scl_prev <= scl_oe_o;
            if (!busy_o)                  falls <= '0;
            else if (scl_prev && !scl_oe_o) falls <= falls + 1'b1;
        end
    end

    // R2
    start_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (scl_oe_o && !sda_oe_o));

    // R4
    sda_grab_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe_o) && busy_o) |-> !scl_oe_o);

    // R4
    sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && sda_oe_o) |=> (sda_oe_o || !busy_o));

    // R5
    pulse_limit_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (falls <= RCV_CW'(RCV_PULSES)));

    // R6
    done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    init_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> init_o);

    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));
endmodule

bind i2c_unstick i2c_unstick_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .init_o   (init_o)
);

// File: tb/i2c_unstick_tb.sv
module i2c_unstick_tb;
    localparam int GAP_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [GAP_W-1:0] gap_i = 8'd1;
    logic             req_i = 1'b0;
    logic             xfer_req_i = 1'b0;
    logic             sda_i;
    logic             scl_oe_o, sda_oe_o, busy_o, done_o, pass_o, init_o;

    int n_chk = 0;
    int n_fail = 0;
    int hold_n = 0;
    int rises = 0;
    int cyc = 0;
    int dones = 0;
    int wd = 0;
    logic prev_scl = 1'b0, last_scl = 1'b0, last_sda = 1'b0;

    typedef struct {
        bit pass;
        int len;
        int pulses;
        bit end_scl;
        bit end_sda;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    // Slave model: holds data low through the first hold_n clock pulses.
    assign sda_i = ~sda_oe_o & ~(rises <= hold_n);

    i2c_unstick #(.GAP_W(GAP_W)) u_dut (
        .clk(clk), .rst(rst), .gap_i(gap_i), .req_i(req_i), .xfer_req_i(xfer_req_i),
        .sda_i(sda_i), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
        .done_o(done_o), .pass_o(pass_o), .init_o(init_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_exp(input int g, input int h);
        exp_t e;
        int ge;
        int k;
        ge = (g == 0) ? 1 : g;
        if (h < 9) begin
            k = h + 1;
            e.pass = 1; e.len = (2 * k + 3) * ge; e.pulses = k;
            e.end_scl = 1; e.end_sda = 1;
        end else begin
            e.pass = 0; e.len = 20 * ge; e.pulses = 9;
            e.end_scl = 1; e.end_sda = 0;
        end
        q.push_back(e);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done_o);
    endtask

    task automatic run_req(input int g, input int h);
        gap_i = GAP_W'(g);
        hold_n = h;
        push_exp(g, h);
        @(negedge clk) req_i = 1'b1;
        @(negedge clk) req_i = 1'b0;
        // R2: first busy cycle pulls the clock with data free
        chk(busy_o && scl_oe_o && !sda_oe_o, "R2 start lines", {busy_o, scl_oe_o, sda_oe_o}, 3'b110);
        wait_done();
        @(negedge clk);
        // R9: lines released once idle
        chk(!scl_oe_o && !sda_oe_o && !busy_o, "R9 idle release", {busy_o, scl_oe_o, sda_oe_o}, 0);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (busy_o) begin
                cyc++;
                if (prev_scl && !scl_oe_o) rises++;
                last_scl = scl_oe_o;
                last_sda = sda_oe_o;
            end
            prev_scl = scl_oe_o;
            if (done_o) begin
                if (q.size() == 0) begin
                    chk(0, "R6 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(pass_o == e.pass, "R4/R5 pass bit (R6)", pass_o, e.pass);
                    chk(cyc == e.len, "R3 busy length", cyc, e.len);
                    chk(rises == e.pulses, "R5 pulse count", rises, e.pulses);
                    chk(last_scl == e.end_scl && last_sda == e.end_sda, "R4/R5 end lines",
                        {last_scl, last_sda}, {e.end_scl, e.end_sda});
                end
                cyc = 0;
                rises = 0;
                dones++;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk({busy_o, done_o, init_o, scl_oe_o, sda_oe_o} == 5'b0, "R1 reset state",
            {busy_o, done_o, init_o, scl_oe_o, sda_oe_o}, 0);

        // R8: automatic run on first transfer
        gap_i = 8'd2; hold_n = 2; push_exp(2, 2);
        @(negedge clk) xfer_req_i = 1'b1;
        @(negedge clk) xfer_req_i = 1'b0;
        chk(busy_o, "R8 auto start", busy_o, 1);
        wait_done();
        chk(init_o, "R8 init set", init_o, 1);
        @(negedge clk) xfer_req_i = 1'b1;
        @(negedge clk) xfer_req_i = 1'b0;
        chk(!busy_o, "R8 no auto start once initialised", busy_o, 0);

        // R3 R4 R5: several slave behaviours and gaps
        run_req(1, 0);
        run_req(3, 3);
        run_req(1, 8);
        run_req(2, 9);
        run_req(0, 5);
        run_req(4, 20);

        // R7: requests during a run are ignored
        gap_i = 8'd3; hold_n = 1; push_exp(3, 1);
        @(negedge clk) req_i = 1'b1;
        @(negedge clk) req_i = 1'b0;
        repeat (5) @(negedge clk);
        req_i = 1'b1; xfer_req_i = 1'b1;
        repeat (3) @(negedge clk);
        req_i = 1'b0; xfer_req_i = 1'b0;
        while (!(busy_o && sda_oe_o && scl_oe_o)) @(negedge clk);
        req_i = 1'b1;
        while (busy_o) @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
        chk(!busy_o, "R7 no extra run", busy_o, 0);

        // R10: request held through the done cycle restarts immediately
        gap_i = 8'd2; hold_n = 4; push_exp(2, 4); push_exp(2, 4);
        @(negedge clk) req_i = 1'b1;
        wait_done();
        @(negedge clk) req_i = 1'b0;
        chk(busy_o, "R10 back-to-back start", busy_o, 1);
        wait_done();
        @(negedge clk);
        chk(q.size() == 0, "R6 all runs completed", q.size(), 0);
        chk(dones == 10, "R6 done count", dones, 10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule